// File: doc/BRIEF.md
# SEC-DED Memory Word Codec

This block is a purely combinational error detection and correction codec. It sits in the data path between a processor and a memory that stores 16-bit words. On a write it computes a check word from the outgoing data. The check word is 6 or 8 bits wide, set by the `CHECK_W` parameter, and the memory stores it beside the data. On a read it takes the data and the check bits as stored, recomputes the check word, and forms a syndrome. The syndrome puts the access into one of three classes: clean, correctable or uncorrectable.

The parity-check columns all have odd weight and are all distinct. This gives single-error correction and double-error detection. The columns are also chosen so that any nonzero error pattern confined to one physical memory device gives a nonzero syndrome. A device is 4 bits wide when `CHECK_W` is 6 and 8 bits wide when `CHECK_W` is 8. A mode input picks automatic correction or detect-only operation. The raw syndrome is exported so that software can analyse errors itself.

Top module: `edac_codec`

## Requirements
- R1: Storing `wr_data_i` with `wr_check_o` and presenting both unchanged on the read inputs gives a zero syndrome, both flags low, and `rd_data_o` equal to `rd_data_i`.
- R2: `syndrome_o` equals the check word recomputed from `rd_data_i`, XOR `rd_check_i`. A corruption of stored check bit k alone therefore yields a syndrome with only bit k set.
- R3: The encoder is linear. All-zero data encodes to an all-zero check word, and check(a XOR b) equals check(a) XOR check(b).
- R4: With `fix_en_i`=1, a single flipped data bit is restored on `rd_data_o`, with `err_corr_o`=1 and `err_uncorr_o`=0.
- R5: A single flipped check bit leaves `rd_data_o` equal to the data input and raises `err_corr_o` only.
- R6: Any two flipped bits anywhere in the stored word raise `err_uncorr_o` only, and `rd_data_o` equals `rd_data_i`.
- R7: Number the stored word with data bit i at position i and check bit j at position 16+j. Device k holds positions 4k..4k+3 when `CHECK_W`=6, or 8k..8k+7 when `CHECK_W`=8; the last device may be narrower. Any nonzero error confined to one device gives a nonzero syndrome and at least one flag high.
- R8: With `fix_en_i`=0 (detect-only), `rd_data_o` always equals `rd_data_i`. The flags and the syndrome behave exactly as in correcting mode.
- R9: The two flags are never high together, and both are low whenever the syndrome is zero. `rd_data_o` differs from `rd_data_i` in at most one bit, and only while `err_corr_o` and `fix_en_i` are both 1.
- R10: An error in an odd number of bits gives a syndrome of odd weight. A nonzero syndrome of even weight always raises `err_uncorr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_data_i | input | 16 | Data word being written |
| wr_check_o | output | CHECK_W | Check word to store with the written data |
| rd_data_i | input | 16 | Data word as read from memory |
| rd_check_i | input | CHECK_W | Check word as read from memory |
| fix_en_i | input | 1 | 1 = correct single-bit errors, 0 = detect only |
| rd_data_o | output | 16 | Read data, corrected when allowed |
| syndrome_o | output | CHECK_W | Raw syndrome |
| err_corr_o | output | 1 | Syndrome matches one codeword column |
| err_uncorr_o | output | 1 | Nonzero syndrome that matches no column |

## Verification
The bench walks every double-bit error over the full stored word for both check widths. A decoder that matched even-weight syndromes, or that produced aliased columns, would flip a wrong data bit there and claim the error was correctable. It sweeps every nonzero pattern inside each memory device. A column set that is linearly dependent within a device would give a zero syndrome and let corrupt data pass as clean. It flips each check bit alone; a design that mapped check-bit syndromes onto data bits would corrupt good data. It repeats single flips in detect-only mode, where a leaking correction path would change the output word.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int unsigned DATA_W = 16;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_FIXABLE = 2'd1,
        ERR_FATAL   = 2'd2
    } err_class_e;

    typedef struct packed {
        err_class_e          cls;
        logic [DATA_W-1:0]   flip;
    } dec_result_t;

    // Parity-check column for codeword position pos (data 0..15, check 16..).
    // Every column has odd weight, all are distinct, and the columns of each
    // memory device are linearly independent.
    function automatic logic [7:0] h_column(input int unsigned chk_w,
                                            input int unsigned pos);
        logic [7:0] col;
        logic [7:0] e8;
        logic [3:0] e4;
        col = '0;
        if (pos >= DATA_W) begin
            col = 8'(1) << (pos - DATA_W);
        end else if (chk_w == 8) begin
            e8  = 8'(1) << (pos % 8);
            col = (pos < 8) ? ~e8 : (e8 ^ 8'h0F);
        end else begin
            e4 = 4'(1) << (pos % 4);
            case (pos / 4)
                0:       col = {2'b00, 2'b11, e4};
                1:       col = {2'b00, 2'b11, ~e4};
                2:       col = {2'b00, 2'b00, ~e4};
                default: begin
                    case (pos % 4)
                        0:       col = 8'b0001_0011;
                        1:       col = 8'b0001_0101;
                        2:       col = 8'b0010_0011;
                        default: col = 8'b0010_0110;
                    endcase
                end
            endcase
        end
        return col;
    endfunction

endpackage

// File: rtl/edac_checkgen.sv
module edac_checkgen
    import edac_pkg::*;
#(
    parameter int unsigned CHECK_W = 6
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic [CHECK_W-1:0] check_o
);

    for (genvar r = 0; r < CHECK_W; r++) begin : g_row
        logic [DATA_W-1:0] taps;
        for (genvar c = 0; c < DATA_W; c++) begin : g_col
            localparam logic [7:0] COL = h_column(CHECK_W, c);
            assign taps[c] = data_i[c] & COL[r];
        end
        assign check_o[r] = ^taps;
    end

endmodule

// File: rtl/edac_syndecode.sv
module edac_syndecode
    import edac_pkg::*;
#(
    parameter int unsigned CHECK_W = 6
) (
    input  logic [CHECK_W-1:0] syn_i,
    output dec_result_t        res_o
);

    localparam int unsigned CODE_W = DATA_W + CHECK_W;

    logic [CODE_W-1:0] hit;

    for (genvar c = 0; c < CODE_W; c++) begin : g_match
        localparam logic [7:0] COL = h_column(CHECK_W, c);
        assign hit[c] = (syn_i == COL[CHECK_W-1:0]);
    end

    always_comb begin
        res_o.flip = hit[DATA_W-1:0];
        if (syn_i == '0) begin
            res_o.cls = ERR_NONE;
        end else if (|hit) begin
            res_o.cls = ERR_FIXABLE;
        end else begin
            res_o.cls = ERR_FATAL;
        end
    end

endmodule

// File: rtl/edac_corrector.sv
module edac_corrector
    import edac_pkg::*;
(
    input  logic [DATA_W-1:0] raw_i,
    input  dec_result_t       res_i,
    input  logic              fix_en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              uncorr_o
);

    always_comb begin
        data_o   = raw_i;
        corr_o   = (res_i.cls == ERR_FIXABLE);
        uncorr_o = (res_i.cls == ERR_FATAL);
        if (fix_en_i && corr_o) begin
            data_o = raw_i ^ res_i.flip;
        end
    end

endmodule

// File: rtl/edac_codec.sv
module edac_codec
    import edac_pkg::*;
#(
    parameter int unsigned CHECK_W = 6
) (
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [CHECK_W-1:0] wr_check_o,
    input  logic [DATA_W-1:0]  rd_data_i,
    input  logic [CHECK_W-1:0] rd_check_i,
    input  logic               fix_en_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [CHECK_W-1:0] syndrome_o,
    output logic               err_corr_o,
    output logic               err_uncorr_o
);

    logic [CHECK_W-1:0] recomputed;
    dec_result_t        dec;

    edac_checkgen #(.CHECK_W(CHECK_W)) u_enc (
        .data_i  (wr_data_i),
        .check_o (wr_check_o)
    );

    edac_checkgen #(.CHECK_W(CHECK_W)) u_recalc (
        .data_i  (rd_data_i),
        .check_o (recomputed)
    );

    assign syndrome_o = recomputed ^ rd_check_i;

    edac_syndecode #(.CHECK_W(CHECK_W)) u_dec (
        .syn_i (syndrome_o),
        .res_o (dec)
    );

    edac_corrector u_fix (
        .raw_i    (rd_data_i),
        .res_i    (dec),
        .fix_en_i (fix_en_i),
        .data_o   (rd_data_o),
        .corr_o   (err_corr_o),
        .uncorr_o (err_uncorr_o)
    );

endmodule

// File: rtl/edac_codec_chk.sv
module edac_codec_chk
    import edac_pkg::*;
#(
    parameter int unsigned CHECK_W = 6
) (
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [CHECK_W-1:0] wr_check_o,
    input logic [DATA_W-1:0]  rd_data_i,
    input logic [CHECK_W-1:0] rd_check_i,
    input logic               fix_en_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic [CHECK_W-1:0] syndrome_o,
    input logic               err_corr_o,
    input logic               err_uncorr_o
);

    always_comb begin
        if (!$isunknown({wr_data_i, wr_check_o, rd_data_i, rd_check_i, fix_en_i,
                         rd_data_o, syndrome_o, err_corr_o, err_uncorr_o})) begin
            // R9
            flags_exclusive_chk: assert (!(err_corr_o && err_uncorr_o))
                else $error("both error flags high");
            // R9
            zero_syn_quiet_chk: assert (syndrome_o != '0 || (!err_corr_o && !err_uncorr_o))
                else $error("flag raised on zero syndrome");
            // R1
            clean_read_chk: assert (!(rd_data_i == wr_data_i && rd_check_i == wr_check_o)
                                    || (syndrome_o == '0 && rd_data_o == rd_data_i))
                else $error("clean word not accepted");
            // R8
            detect_passthru_chk: assert (fix_en_i || rd_data_o == rd_data_i)
                else $error("data changed in detect-only mode");
            // R6
            uncorr_passthru_chk: assert (!err_uncorr_o || rd_data_o == rd_data_i)
                else $error("data changed on uncorrectable error");
            // R9
            single_flip_chk: assert ($countones(rd_data_o ^ rd_data_i)
                                     <= ((err_corr_o && fix_en_i) ? 1 : 0))
                else $error("output differs from input beyond one corrected bit");
            // R10
            even_syn_fatal_chk: assert (syndrome_o == '0 || (^syndrome_o) || err_uncorr_o)
                else $error("even-weight syndrome not flagged uncorrectable");
        end
    end

endmodule

bind edac_codec edac_codec_chk #(.CHECK_W(CHECK_W)) u_chk (
    .wr_data_i    (wr_data_i),
    .wr_check_o   (wr_check_o),
    .rd_data_i    (rd_data_i),
    .rd_check_i   (rd_check_i),
    .fix_en_i     (fix_en_i),
    .rd_data_o    (rd_data_o),
    .syndrome_o   (syndrome_o),
    .err_corr_o   (err_corr_o),
    .err_uncorr_o (err_uncorr_o)
);

// File: tb/sim_edac_codec.sv
`timescale 1ns/1ps
module sim_edac_codec;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [15:0] data = '0;
    logic        mode = 1'b1;
    logic [21:0] em0 = '0;
    logic [23:0] em1 = '0;

    logic [5:0]  chk0, syn0, rdc0;
    logic [7:0]  chk1, syn1, rdc1;
    logic [15:0] out0, out1, rdd0, rdd1;
    logic        c0, f0, c1, f1;

    assign rdd0 = data ^ em0[15:0];
    assign rdc0 = chk0 ^ em0[21:16];
    assign rdd1 = data ^ em1[15:0];
    assign rdc1 = chk1 ^ em1[23:16];

    edac_codec #(.CHECK_W(6)) u0 (
        .wr_data_i(data), .wr_check_o(chk0), .rd_data_i(rdd0), .rd_check_i(rdc0),
        .fix_en_i(mode), .rd_data_o(out0), .syndrome_o(syn0),
        .err_corr_o(c0), .err_uncorr_o(f0)
    );

    edac_codec #(.CHECK_W(8)) u1 (
        .wr_data_i(data), .wr_check_o(chk1), .rd_data_i(rdd1), .rd_check_i(rdc1),
        .fix_en_i(mode), .rd_data_o(out1), .syndrome_o(syn1),
        .err_corr_o(c1), .err_uncorr_o(f1)
    );

    // {data, dmask, cmask, mode, exp_corr, exp_uncorr, exp_out}
    localparam int NV = 11;
    localparam logic [58:0] VEC [NV] = '{
        {16'h1234, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 16'h1234},
        {16'h1234, 16'h0001, 8'h00, 1'b1, 1'b1, 1'b0, 16'h1234},
        {16'hA5A5, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, 16'hA5A5},
        {16'hFFFF, 16'h0000, 8'h04, 1'b1, 1'b1, 1'b0, 16'hFFFF},
        {16'h0F0F, 16'h0003, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0F0C},
        {16'h0F0F, 16'h0010, 8'h01, 1'b1, 1'b0, 1'b1, 16'h0F1F},
        {16'h0000, 16'h0000, 8'h21, 1'b1, 1'b0, 1'b1, 16'h0000},
        {16'hBEEF, 16'h0100, 8'h00, 1'b0, 1'b1, 1'b0, 16'hBFEF},
        {16'hBEEF, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 16'hBEEF},
        {16'h5555, 16'h0300, 8'h00, 1'b0, 1'b0, 1'b1, 16'h5655},
        {16'hC3C3, 16'h0000, 8'h02, 1'b0, 1'b1, 1'b0, 16'hC3C3}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    initial begin
        logic [15:0] ca0, cb0;
        logic [7:0]  ca1, cb1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        settle();
        // R3 R1: idle inputs all zero
        check("R3", "zero data check6", 32'(chk0), 32'h0);
        check("R3", "zero data check8", 32'(chk1), 32'h0);
        check("R1", "idle flags", {28'h0, c0, f0, c1, f1}, 32'h0);

        // vector table, both widths
        for (int i = 0; i < NV; i++) begin
            data = VEC[i][58:43];
            em0  = {VEC[i][24:19], VEC[i][42:27]};
            em1  = {VEC[i][26:19], VEC[i][42:27]};
            mode = VEC[i][18];
            settle();
            check("R4/R5/R6/R8", $sformatf("vec %0d w6", i),
                  {14'h0, c0, f0, out0}, {14'h0, VEC[i][17], VEC[i][16], VEC[i][15:0]});
            check("R4/R5/R6/R8", $sformatf("vec %0d w8", i),
                  {14'h0, c1, f1, out1}, {14'h0, VEC[i][17], VEC[i][16], VEC[i][15:0]});
        end

        // R1: clean reads of several words
        mode = 1'b1;
        em0 = '0;
        em1 = '0;
        for (int i = 0; i < 8; i++) begin
            data = 16'h9E37 * 16'(i + 1) ^ 16'h00FF;
            settle();
            check("R1", "clean read", {c0, f0, c1, f1, 6'(syn0), syn1, out0 ^ data, out1 ^ data},
                  32'h0);
        end

        // R3: linearity of the encoder
        for (int i = 0; i < 6; i++) begin
            logic [15:0] a, b;
            logic [5:0]  x0;
            logic [7:0]  x1;
            a = 16'h1357 ^ 16'(i * 16'h2221);
            b = 16'hC0DE + 16'(i * 16'h0F03);
            data = a; settle(); x0 = chk0; x1 = chk1;
            data = b; settle(); ca0 = 16'(chk0); ca1 = chk1;
            data = a ^ b; settle(); cb0 = 16'(chk0); cb1 = chk1;
            check("R3", "linear w6", 32'(cb0), 32'(ca0 ^ 16'(x0)));
            check("R3", "linear w8", 32'(cb1), 32'(ca1 ^ x1));
        end

        // R4 and R8: every single data-bit flip, both modes
        data = 16'h6B3D;
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            for (int b = 0; b < 16; b++) begin
                em0 = 22'(1) << b;
                em1 = 24'(1) << b;
                settle();
                if (m == 1) begin
                    check("R4", $sformatf("fix bit %0d w6", b), {14'h0, c0, f0, out0},
                          {14'h0, 1'b1, 1'b0, data});
                    check("R4", $sformatf("fix bit %0d w8", b), {14'h0, c1, f1, out1},
                          {14'h0, 1'b1, 1'b0, data});
                end else begin
                    check("R8", $sformatf("detect bit %0d w6", b), {14'h0, c0, f0, out0},
                          {14'h0, 1'b1, 1'b0, data ^ em0[15:0]});
                    check("R8", $sformatf("detect bit %0d w8", b), {14'h0, c1, f1, out1},
                          {14'h0, 1'b1, 1'b0, data ^ em1[15:0]});
                end
            end
        end

        // R2 and R5: each check bit alone
        mode = 1'b1;
        for (int k = 0; k < 8; k++) begin
            em1 = 24'(1) << (16 + k);
            em0 = (k < 6) ? 22'(1) << (16 + k) : '0;
            settle();
            check("R2", $sformatf("check bit %0d w8 syndrome", k), 32'(syn1), 32'(8'(1) << k));
            check("R5", $sformatf("check bit %0d w8", k), {14'h0, c1, f1, out1},
                  {14'h0, 1'b1, 1'b0, data});
            if (k < 6) begin
                check("R2", $sformatf("check bit %0d w6 syndrome", k), 32'(syn0),
                      32'(6'(1) << k));
                check("R5", $sformatf("check bit %0d w6", k), {14'h0, c0, f0, out0},
                      {14'h0, 1'b1, 1'b0, data});
            end
        end

        // R6: every double error, both widths
        em1 = '0;
        for (int i = 0; i < 22; i++) begin
            for (int j = i + 1; j < 22; j++) begin
                em0 = (22'(1) << i) | (22'(1) << j);
                settle();
                check("R6", $sformatf("pair %0d,%0d w6", i, j), {14'h0, c0, f0, out0},
                      {14'h0, 1'b0, 1'b1, data ^ em0[15:0]});
            end
        end
        em0 = '0;
        for (int i = 0; i < 24; i++) begin
            for (int j = i + 1; j < 24; j++) begin
                em1 = (24'(1) << i) | (24'(1) << j);
                settle();
                check("R6", $sformatf("pair %0d,%0d w8", i, j), {14'h0, c1, f1, out1},
                      {14'h0, 1'b0, 1'b1, data ^ em1[15:0]});
            end
        end

        // R7 and R10: every pattern inside each device
        em1 = '0;
        for (int d = 0; d < 6; d++) begin
            for (int p = 1; p < 16; p++) begin
                em0 = 22'(p) << (4 * d);
                if (em0 != '0) begin
                    settle();
                    check("R7", $sformatf("dev %0d pat %h w6", d, p),
                          {30'h0, syn0 != '0, c0 | f0}, {30'h0, 2'b11});
                    check("R10", $sformatf("dev %0d pat %h w6 parity", d, p),
                          {30'h0, ^syn0, ($countones(em0) % 2 == 0) ? f0 : 1'b1},
                          {30'h0, 1'(($countones(em0)) % 2), 1'b1});
                end
            end
        end
        em0 = '0;
        for (int d = 0; d < 3; d++) begin
            for (int p = 1; p < 256; p++) begin
                em1 = 24'(p) << (8 * d);
                settle();
                check("R7", $sformatf("dev %0d pat %h w8", d, p),
                      {30'h0, syn1 != '0, c1 | f1}, {30'h0, 2'b11});
                check("R10", $sformatf("dev %0d pat %h w8 parity", d, p),
                      {30'h0, ^syn1, ($countones(em1) % 2 == 0) ? f1 : 1'b1},
                      {30'h0, 1'(($countones(em1)) % 2), 1'b1});
            end
        end

        done = 1'b1;
        summary();
    end

endmodule